// File: doc/BRIEF.md
# Configurable External Interrupt Forwarder

This block sits between a bank of external interrupt wires and a downstream interrupt controller. It accepts `LINES` (32 by default) asynchronous inputs. Each input passes through a synchroniser and a sense stage, and the result is held in a per-line request latch. Every line drives its own output, which is a registered, active-high level request. Each line can be set to one of four sense types: high level, low level, rising edge or falling edge.

A mask bit per line holds the output low without stopping the latch, so an event that arrives while a line is masked is kept and can be seen in the raw status. Software reaches the configuration and status through a small synchronous register bus with eight word slots. Latched requests are removed by writing ones to a clear register. A single write of all ones can clear every line, and a single write of all ones can mask every line.

Top module: `ext_irq_router`

## Requirements
- R1: There are `LINES` inputs, and each one drives its own output of the same index. Outputs are active-high level requests.
- R2: The bus selects a 32-bit word by `bus_sel`. Slot 0 is mask, 1 is spare storage A, 2 is masked status, 3 is raw status, 4 is clear, 5 is polarity, 6 is edge mode and 7 is spare storage B. A read returns data on `bus_rdata` after the clock edge that samples the request.
- R3: After reset, mask reads all ones, polarity and edge mode read zero, every latch is cleared and every output is low.
- R4: A mask bit of 1 forces that line's output low. The line keeps latching events while it is masked, and raw status shows them.
- R5: Writing 1 to a clear bit removes that line's latched request. Writing 0 changes nothing. Reads of the clear slot return 0.
- R6: Edge-mode bit 1 selects edge sensing and 0 selects level sensing. Polarity bit 1 selects high level or rising edge, and 0 selects low level or falling edge.
- R7: A level-sensed line sets its latch again on every cycle its input is still active. When an event and a clear hit the same line in the same cycle, the event wins.
- R8: Masked status equals raw AND NOT mask, and this value drives the outputs. A change on an input reaches the output after four clock edges: two synchroniser stages, the latch, and the output register.
- R9: One write of all ones to the clear slot clears every line. One write of all ones to the mask slot masks every line.
- R10: Spare storage slots A and B read back what was written to them and have no effect on sensing or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | LINES | Asynchronous external interrupt inputs |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_sel | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | LINES | Write data |
| bus_rdata | output | LINES | Registered read data |
| irq_out | output | LINES | Level, active-high requests to the downstream controller |

## Verification
The assertions assume `rst` is synchronous and held for at least one edge. They also assume every bus access lasts one cycle, with `bus_we` meaningful only while `bus_en` is high. The stimulus changes `irq_in` and the bus signals only on falling clock edges, and it never issues more than one access per cycle. Because inputs never change near a rising edge, the synchroniser always settles within the four-edge latency. For the same reason, the race between an event and a clear can be placed on an exact cycle.

// File: rtl/eir_pkg.sv
package eir_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SLOT_MASK  = 3'd0,
    SLOT_SPA   = 3'd1,
    SLOT_STAT  = 3'd2,
    SLOT_RAW   = 3'd3,
    SLOT_CLR   = 3'd4,
    SLOT_POL   = 3'd5,
    SLOT_EDGE  = 3'd6,
    SLOT_SPB   = 3'd7
  } slot_e;
endpackage

// File: rtl/eir_sync.sv
module eir_sync #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] async_i,
  output logic [LINES-1:0] sync_o,
  output logic [LINES-1:0] prev_o
);
  logic [LINES-1:0] meta_q;
  logic [LINES-1:0] sync_q;
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;

  // R8: the delayed copy follows the synchronised value one cycle later
  p_prev_follows_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (prev_q == $past(sync_q)));
endmodule

// File: rtl/eir_sense.sv
module eir_sense #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] sync_i,
  input  logic [LINES-1:0] prev_i,
  input  logic [LINES-1:0] pol_i,
  input  logic [LINES-1:0] edge_i,
  input  logic [LINES-1:0] clr_i,
  output logic [LINES-1:0] raw_o
);
  logic [LINES-1:0] hit;
  logic [LINES-1:0] lat_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic rise, fall;
    assign rise = sync_i[g] & ~prev_i[g];
    assign fall = ~sync_i[g] & prev_i[g];

    always_comb begin
      if (edge_i[g]) hit[g] = pol_i[g] ? rise : fall;
      else           hit[g] = (sync_i[g] == pol_i[g]);
    end

    always_ff @(posedge clk) begin
      if (rst)           lat_q[g] <= 1'b0;
      else if (hit[g])   lat_q[g] <= 1'b1;
      else if (clr_i[g]) lat_q[g] <= 1'b0;
    end

    // R7: an event always lands in the latch, even with a clear alongside
    p_event_wins_r7: assert property (@(posedge clk) disable iff (rst)
      hit[g] |=> lat_q[g]);
    // R5: a clear without a competing event empties the latch
    p_clear_takes_r5: assert property (@(posedge clk) disable iff (rst)
      (clr_i[g] && !hit[g]) |=> !lat_q[g]);
    // R4: without event or clear the latch holds, whatever the mask does
    p_latch_holds_r4: assert property (@(posedge clk) disable iff (rst)
      (!clr_i[g] && !hit[g]) |=> $stable(lat_q[g]));
  end

  assign raw_o = lat_q;
endmodule

// File: rtl/eir_regs.sv
module eir_regs
  import eir_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [SEL_W-1:0] bus_sel,
  input  logic [LINES-1:0] bus_wdata,
  output logic [LINES-1:0] bus_rdata,
  input  logic [LINES-1:0] raw_i,
  input  logic [LINES-1:0] stat_i,
  output logic [LINES-1:0] mask_o,
  output logic [LINES-1:0] pol_o,
  output logic [LINES-1:0] edge_o,
  output logic [LINES-1:0] clr_o
);
  slot_e            slot;
  logic             wr, rd;
  logic [LINES-1:0] mask_q, pol_q, edge_q, spa_q, spb_q, rdata_q;
  logic [LINES-1:0] rd_mux;

  assign slot = slot_e'(bus_sel);
  assign wr   = bus_en & bus_we;
  assign rd   = bus_en & ~bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      pol_q  <= '0;
      edge_q <= '0;
      spa_q  <= '0;
      spb_q  <= '0;
    end else if (wr) begin
      case (slot)
        SLOT_MASK: mask_q <= bus_wdata;
        SLOT_SPA:  spa_q  <= bus_wdata;
        SLOT_POL:  pol_q  <= bus_wdata;
        SLOT_EDGE: edge_q <= bus_wdata;
        SLOT_SPB:  spb_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (slot)
      SLOT_MASK: rd_mux = mask_q;
      SLOT_SPA:  rd_mux = spa_q;
      SLOT_STAT: rd_mux = stat_i;
      SLOT_RAW:  rd_mux = raw_i;
      SLOT_POL:  rd_mux = pol_q;
      SLOT_EDGE: rd_mux = edge_q;
      SLOT_SPB:  rd_mux = spb_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign clr_o     = (wr && slot == SLOT_CLR) ? bus_wdata : '0;
  assign mask_o    = mask_q;
  assign pol_o     = pol_q;
  assign edge_o    = edge_q;
  assign bus_rdata = rdata_q;

  // R5: the clear slot never reads back anything but zero
  p_clear_reads_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rd && slot == SLOT_CLR) |=> (bus_rdata == '0));
  // R3: reset leaves every line masked
  p_reset_masked_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mask_o == '1));
  // R2: read data only moves on a read
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(bus_rdata));
endmodule

// File: rtl/ext_irq_router.sv
module ext_irq_router
  import eir_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] irq_in,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [SEL_W-1:0] bus_sel,
  input  logic [LINES-1:0] bus_wdata,
  output logic [LINES-1:0] bus_rdata,
  output logic [LINES-1:0] irq_out
);
  logic [LINES-1:0] sync_v, prev_v, pol_v, edge_v, clr_v, mask_v, raw_v, stat_v;
  logic [LINES-1:0] out_q;

  eir_sync #(.LINES(LINES)) u_sync (
    .clk(clk), .rst(rst), .async_i(irq_in), .sync_o(sync_v), .prev_o(prev_v)
  );

  eir_sense #(.LINES(LINES)) u_sense (
    .clk(clk), .rst(rst), .sync_i(sync_v), .prev_i(prev_v), .pol_i(pol_v),
    .edge_i(edge_v), .clr_i(clr_v), .raw_o(raw_v)
  );

  eir_regs #(.LINES(LINES)) u_regs (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .raw_i(raw_v), .stat_i(stat_v),
    .mask_o(mask_v), .pol_o(pol_v), .edge_o(edge_v), .clr_o(clr_v)
  );

  assign stat_v = raw_v & ~mask_v;

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= stat_v;
  end

  assign irq_out = out_q;

  // R4: a line masked in the previous cycle never drives its output
  p_mask_forces_low_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_out & $past(mask_v)) == '0));
  // R8: an output is only high if its latch was set the cycle before
  p_out_from_latch_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_out & ~$past(raw_v)) == '0));
endmodule

// File: tb/ext_irq_router_bench.sv
module ext_irq_router_bench;
  localparam int LINES = 32;
  localparam logic [2:0] S_MASK = 3'd0, S_SPA = 3'd1, S_STAT = 3'd2, S_RAW = 3'd3,
                         S_CLR = 3'd4, S_POL = 3'd5, S_EDGE = 3'd6, S_SPB = 3'd7;

  // {polarity, edge, input before clear, input after unmask, expected latch}
  localparam logic [4:0] VEC [8] = '{
    5'b10_0_1_1, 5'b10_0_0_0, 5'b00_1_0_1, 5'b00_1_1_0,
    5'b11_0_1_1, 5'b11_1_0_0, 5'b01_1_0_1, 5'b01_0_1_0
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LINES-1:0] irq_in = '0;
  logic             bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0]       bus_sel = '0;
  logic [LINES-1:0] bus_wdata = '0;
  logic [LINES-1:0] bus_rdata, irq_out;
  logic [LINES-1:0] rv;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_router #(.LINES(LINES)) u_ext_irq_router (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_en(bus_en), .bus_we(bus_we),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(string tag, logic [LINES-1:0] act, logic [LINES-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] s, logic [LINES-1:0] d);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b1; bus_sel = s; bus_wdata = d;
    @(posedge clk);
    @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] s, output logic [LINES-1:0] d);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b0; bus_sel = s;
    @(posedge clk);
    @(negedge clk); bus_en = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R3 reset state
    chk("R3 outputs low", irq_out, '0);
    rd(S_MASK, rv); chk("R3 mask all ones", rv, '1);
    rd(S_POL, rv);  chk("R3 polarity zero", rv, '0);
    rd(S_EDGE, rv); chk("R3 edge zero", rv, '0);
    // R5 reads of the clear slot
    rd(S_CLR, rv);  chk("R5 clear reads zero", rv, '0);

    // R6 R1 table walk over the four sense types
    for (int v = 0; v < 8; v++) begin
      int ln = v * 4 + 1;
      logic [LINES-1:0] bit_m = '0;
      bit_m[ln] = 1'b1;
      wr(S_POL,  VEC[v][4] ? bit_m : '0);
      wr(S_EDGE, VEC[v][3] ? bit_m : '0);
      irq_in[ln] = VEC[v][2];
      idle(6);
      wr(S_CLR, bit_m);
      idle(2);
      wr(S_MASK, ~bit_m);
      irq_in[ln] = VEC[v][1];
      idle(6);
      rd(S_RAW, rv);
      chk("R6 sense latch", {31'b0, rv[ln]}, {31'b0, VEC[v][0]});
      chk("R1 own output", {31'b0, irq_out[ln]}, {31'b0, VEC[v][0]});
      wr(S_MASK, '1);
      irq_in[ln] = 1'b0;
    end

    // R10 spare storage
    wr(S_SPA, 32'hA5A5_0F0F);
    wr(S_SPB, 32'h1234_5678);
    rd(S_SPA, rv); chk("R10 spare A", rv, 32'hA5A5_0F0F);
    rd(S_SPB, rv); chk("R10 spare B", rv, 32'h1234_5678);
    chk("R10 outputs untouched", irq_out, '0);

    // R4 masked line keeps latching
    wr(S_POL, 32'h0000_0020); wr(S_EDGE, 32'h0000_0020);
    idle(4); wr(S_CLR, 32'h0000_0020); idle(2);
    irq_in[5] = 1'b1; idle(6); irq_in[5] = 1'b0; idle(4);
    chk("R4 masked output low", {31'b0, irq_out[5]}, 32'h0);
    rd(S_RAW, rv);  chk("R4 raw holds masked event", {31'b0, rv[5]}, 32'h1);
    rd(S_STAT, rv); chk("R8 status hides masked", {31'b0, rv[5]}, 32'h0);
    wr(S_MASK, ~32'h0000_0020); idle(2);
    chk("R4 unmask releases", {31'b0, irq_out[5]}, 32'h1);
    rd(S_STAT, rv); chk("R8 status after unmask", {31'b0, rv[5]}, 32'h1);

    // R5 zero write ignored, one write clears
    wr(S_CLR, 32'h0); idle(2);
    rd(S_RAW, rv); chk("R5 zero clear ignored", {31'b0, rv[5]}, 32'h1);
    wr(S_CLR, 32'h0000_0020); idle(2);
    rd(S_RAW, rv); chk("R5 clear removes", {31'b0, rv[5]}, 32'h0);
    chk("R5 output drops", {31'b0, irq_out[5]}, 32'h0);
    wr(S_MASK, '1);

    // R7 level line re-latches while active
    wr(S_POL, 32'h0000_0080); wr(S_EDGE, 32'h0);
    irq_in[7] = 1'b1; idle(6);
    wr(S_CLR, 32'h0000_0080); idle(2);
    rd(S_RAW, rv); chk("R7 level re-latch", {31'b0, rv[7]}, 32'h1);
    irq_in[7] = 1'b0; idle(6);
    wr(S_CLR, 32'h0000_0080); idle(2);
    rd(S_RAW, rv); chk("R7 clear after release", {31'b0, rv[7]}, 32'h0);

    // R7 event and clear in the same cycle
    wr(S_POL, 32'h0000_0200); wr(S_EDGE, 32'h0000_0200);
    idle(4); wr(S_CLR, 32'h0000_0200); idle(2);
    @(negedge clk); irq_in[9] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b1; bus_sel = S_CLR; bus_wdata = 32'h0000_0200;
    @(posedge clk);
    @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
    rd(S_RAW, rv); chk("R7 event beats clear", {31'b0, rv[9]}, 32'h1);
    wr(S_CLR, 32'h0000_0200); idle(2);
    rd(S_RAW, rv); chk("R7 later clear works", {31'b0, rv[9]}, 32'h0);
    irq_in[9] = 1'b0;

    // R8 four-edge latency
    wr(S_POL, 32'h0000_0008); wr(S_EDGE, 32'h0);
    idle(4); wr(S_CLR, 32'h0000_0008); wr(S_MASK, ~32'h0000_0008); idle(2);
    @(negedge clk); irq_in[3] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R8 not yet after three edges", {31'b0, irq_out[3]}, 32'h0);
    @(posedge clk);
    @(negedge clk); chk("R8 high after four edges", {31'b0, irq_out[3]}, 32'h1);
    irq_in[3] = 1'b0;

    // R9 bulk clear and bulk mask
    wr(S_POL, '1); wr(S_EDGE, '0);
    irq_in = '1; idle(6); irq_in = '0; idle(6);
    rd(S_RAW, rv); chk("R9 all latched", rv, '1);
    wr(S_CLR, '1); idle(2);
    rd(S_RAW, rv); chk("R9 one write clears all", rv, '0);
    irq_in = '1; wr(S_MASK, '0); idle(6);
    chk("R9 all outputs high unmasked", irq_out, '1);
    wr(S_MASK, '1); idle(2);
    rd(S_MASK, rv); chk("R9 mask all ones", rv, '1);
    chk("R9 one write masks all", irq_out, '0);
    irq_in = '0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule